// File: doc/BRIEF.md
# Serial CRC-16 Generator and Checker

This block computes a 16-bit cyclic redundancy remainder over a serial bit stream, one bit per accepted cycle, using the generator polynomial x^16 + x^15 + x^2 + 1. It is a plain linear feedback shift register. An XOR sits in front of every stage whose polynomial coefficient is 1, and the top stage drives the feedback. The register starts from zero, and input bits enter most significant bit first with no reflection of any kind. After each accepted bit the register holds the remainder of the stream seen so far, divided by the polynomial in modulo-2 arithmetic.

To generate a check value, clear the register, shift in the message and then sixteen zero bits. The remainder output then holds the value to append to the message. To check a received codeword, clear the register and shift in the message followed by its received remainder, with no zeros appended. A zero-remainder flag, decoded directly from the register, is high after the last bit when the codeword is intact. Any nonzero result marks a corrupted word. The flag means something only once the last bit has been shifted in.

A two-state controller tracks whether the register can still be zero by construction:
- `ST_EMPTY`: entered on reset or clear. Only zero bits have been seen since then.
- `ST_ACCUM`: entered when a 1 bit is accepted while in `ST_EMPTY`. The controller stays in `ST_ACCUM` until the next clear.

The controller also arbitrates between clear and shift.

Top module: `crc16_serial`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the remainder output is 0x0000 and the zero flag is 1.
- R2: A high `clear` sets all stages to zero at the next clock edge. It takes priority over `bit_valid`: a bit offered in the same cycle is dropped.
- R3: When `bit_valid` is low and `clear` is low, the remainder holds its value whatever `bit_in` does.
- R4: Each accepted bit moves the register one place toward the top. The new stage 0 is `bit_in` XOR old stage 15. The new stages 2 and 15 are the stage below XOR old stage 15. Every other stage takes the old value of the stage below it. Example: from 0x8005, accepting a 1 gives 0x800E.
- R5: A message shifted MSB first from a cleared register, followed by 16 zero bits, leaves the remainder of message·x^16 divided by the polynomial. Example: a single 1 bit followed by 16 zeros gives 0x8005.
- R6: A message followed by its R5 remainder (remainder MSB first) leaves the register at 0x0000 with the zero flag at 1.
- R7: A codeword with one bit inverted leaves a nonzero register and the zero flag at 0.
- R8: The zero flag is 1 exactly when all 16 stages are zero, and it follows the register in the same cycle.
- R9: Zero bits accepted from a cleared register leave it at zero, so the controller's empty state always coincides with a zero register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Zero the register at the next edge; overrides bit_valid |
| bit_valid | input | 1 | bit_in is accepted at this edge |
| bit_in | input | 1 | Serial data bit, most significant first |
| remainder | output | 16 | Current register contents, bit 15 is stage 15 |
| rem_zero | output | 1 | High when the remainder is zero |

## Verification
The bench builds the block with its defaults: a 16-bit register and the polynomial 0x8005, given by its low coefficients. The tap layout that the generate loop produces is therefore the one under test. Because messages run up to 32 bits, the top stage is set many times and the feedback path is exercised. The bench checks each expected remainder against its own long-division model. It then feeds the message back with that remainder to reach the zero-remainder case, and inverts single bits to reach the error case.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    localparam int          CRC_W    = 16;
    // Low coefficients of x^16 + x^15 + x^2 + 1 (x^16 implied)
    localparam logic [15:0] CRC_POLY = 16'h8005;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_ACCUM = 1'b1
    } crc_state_e;
endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
    import crc16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       bit_valid,
    input  logic       bit_in,
    output logic       shift_en,
    output logic       clr_en,
    output crc_state_e state
);
    crc_state_e state_nxt;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (!clear && bit_valid && bit_in) state_nxt = ST_ACCUM;
            end
            ST_ACCUM: begin
                if (clear) state_nxt = ST_EMPTY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    // Outputs: clear wins over a data bit offered in the same cycle
    always_comb begin
        clr_en   = clear;
        shift_en = bit_valid && !clear;
    end

    p_accum_needs_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY && shift_en && !bit_in) |=> (state == ST_EMPTY));
endmodule

// File: rtl/crc16_shreg.sv
module crc16_shreg #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   POLY = 16'h8005
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    localparam int TOP = W - 1;

    logic [W-1:0] nxt;
    logic         fb;

    assign fb = q[TOP];

    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_lsb
            assign nxt[i] = din ^ fb;
        end else if (POLY[i]) begin : g_tap
            assign nxt[i] = q[i-1] ^ fb;
        end else begin : g_pass
            assign nxt[i] = q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (clr)   q <= '0;
        else if (shift) q <= nxt;
    end

    // Stages without a tap copy their lower neighbour (R4)
    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr && !q[TOP]) |=> (q[TOP:1] == $past(q[TOP-1:0])));
endmodule

// File: rtl/crc16_serial.sv
module crc16_serial
    import crc16_pkg::*;
#(
    parameter int               WIDTH = CRC_W,
    parameter logic [WIDTH-1:0] POLY  = CRC_POLY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [WIDTH-1:0] remainder,
    output logic             rem_zero
);
    localparam int MSB = WIDTH - 1;

    logic       shift_en;
    logic       clr_en;
    crc_state_e state;

    crc16_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .shift_en  (shift_en),
        .clr_en    (clr_en),
        .state     (state)
    );

    crc16_shreg #(.W(WIDTH), .POLY(POLY)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_en),
        .shift (shift_en),
        .din   (bit_in),
        .q     (remainder)
    );

    assign rem_zero = ~|remainder;

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (remainder == '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !bit_valid) |=> $stable(remainder));

    p_lsb_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !clear) |=> (remainder[0] == ($past(bit_in) ^ $past(remainder[MSB]))));

    p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |-> rem_zero);
endmodule

// File: tb/tb_crc16_serial.sv
module tb_crc16_serial;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam logic [31:0] V_MSG [NV] = '{32'h1, 32'hA5, 32'h0, 32'h3132, 32'hFFFFFFFF,
                                           32'h8000_0001, 32'h1234_5678, 32'h7};
    localparam int V_LEN [NV] = '{1, 8, 8, 16, 32, 32, 32, 3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic [15:0] remainder;
    logic        rem_zero;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    crc16_serial dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .bit_valid(bit_valid),
        .bit_in(bit_in), .remainder(remainder), .rem_zero(rem_zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Independent model: long division of msg*x^16 by the 17-bit divisor
    function automatic logic [15:0] div_rem(input logic [31:0] msg, input int len);
        logic [47:0] d;
        d = {msg, 16'h0000};
        for (int i = 47; i >= 16; i--) begin
            if (i < len + 16 && d[i]) d[i -: 17] = d[i -: 17] ^ 17'h18005;
        end
        return d[15:0];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic feed(input logic b);
        @(negedge clk); bit_valid = 1'b1; bit_in = b;
        @(negedge clk); bit_valid = 1'b0; bit_in = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic feed_word(input logic [31:0] w, input int len);
        for (int i = len - 1; i >= 0; i--) feed(w[i]);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] e;
        repeat (3) @(negedge clk);
        chk("R1 reset reg", remainder, 16'h0000);
        chk("R1 reset flag", {15'd0, rem_zero}, 16'h0001);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", remainder, 16'h0000);

        // Vector table: generate, then check the codeword
        for (int v = 0; v < NV; v++) begin
            e = div_rem(V_MSG[v], V_LEN[v]);
            do_clear();
            feed_word(V_MSG[v], V_LEN[v]);
            feed_word(32'h0, 16);
            chk("R5 remainder", remainder, e);
            chk("R8 flag", {15'd0, rem_zero}, {15'd0, (e == 16'h0)});
            do_clear();
            feed_word(V_MSG[v], V_LEN[v]);
            feed_word({16'h0, e}, 16);
            chk("R6 codeword reg", remainder, 16'h0000);
            chk("R6 codeword flag", {15'd0, rem_zero}, 16'h0001);
        end

        // R5 known value
        chk("R5 single one", div_rem(32'h1, 1), 16'h8005);

        // R4 step-by-step feedback
        do_clear();
        feed(1'b1);
        chk("R4 first bit", remainder, 16'h0001);
        feed_word(32'h0, 15);
        chk("R4 walk to top", remainder, 16'h8000);
        feed(1'b0);
        chk("R4 feedback zero in", remainder, 16'h8005);
        feed(1'b1);
        chk("R4 feedback one in", remainder, 16'h800E);

        // R3 hold with valid low while bit_in toggles
        @(negedge clk); bit_in = 1'b1;
        @(negedge clk); bit_in = 1'b0;
        @(negedge clk); bit_in = 1'b1;
        @(negedge clk); bit_in = 1'b0;
        chk("R3 hold", remainder, 16'h800E);
        chk("R8 nonzero flag", {15'd0, rem_zero}, 16'h0000);

        // R2 clear beats a valid bit in the same cycle
        @(negedge clk); clear = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk); clear = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        chk("R2 clear priority", remainder, 16'h0000);
        chk("R2 clear flag", {15'd0, rem_zero}, 16'h0001);

        // R9 leading zeros leave a cleared register at zero
        feed_word(32'h0, 5);
        chk("R9 zeros stay zero", remainder, 16'h0000);
        chk("R9 flag", {15'd0, rem_zero}, 16'h0001);

        // R7 corrupted codewords
        for (int f = 0; f < 3; f++) begin
            logic [47:0] cw;
            e = div_rem(32'h1234_5678, 32);
            cw = {32'h1234_5678, e};
            cw[f * 17] = ~cw[f * 17];
            do_clear();
            for (int i = 47; i >= 0; i--) feed(cw[i]);
            chk("R7 error flag", {15'd0, rem_zero}, 16'h0000);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule